// File: doc/BRIEF.md
# Rotate-Through-Carry Instruction Executor

This block carries out one single-word instruction: it takes an 8-bit operand from data memory and shifts it left by one position, with the carry flag closing the loop. The old carry goes into the lowest bit, and the bit that leaves the top becomes the new carry. The block also checks the instruction word and picks a 12-bit data address. That address comes either from a fixed access bank or from a bank-select value supplied beside the instruction. It then sends the result to the working register or back to memory, and updates the carry, negative and zero flags.

A host presents a 16-bit word with `instr_valid` while the block is idle. The block steps through named states:
- `ST_IDLE` to `ST_DECODE` when it accepts a word.
- `ST_DECODE` to `ST_READ` on an opcode match, or back to `ST_IDLE` on a mismatch.
- `ST_READ` to `ST_PROCESS` to `ST_WRITE` to `ST_IDLE`.

Memory reads are synchronous: data requested in one cycle arrives on `mem_rdata` in the next. `done` pulses once when the result and flags are visible. `illegal` pulses once for a word that is not this instruction.

Top module: `rlc_exec`

## Requirements
- R1: The result is the operand shifted left by one with the previous carry in bit 0; the new carry is operand bit 7 (operand 0xE6 with carry 0 gives 0xCC and carry 1).
- R2: A word is accepted as this instruction only when bits 15:10 equal 001101. Bit 9 is the destination select, bit 8 is the bank mode and bits 7:0 are the file offset.
- R3: With destination select 0, the result goes to `wreg` and memory is not written. With destination select 1, the result is written to the operand address and `wreg` is unchanged.
- R4: With bank mode 0 the address is {4'h0, offset} for offsets 0x00–0x7F and {4'hF, offset} for offsets 0x80–0xFF. `bsr` has no effect.
- R5: With bank mode 1 the address is {bsr, offset}, using the `bsr` value sampled when the word was accepted.
- R6: `flag_n` equals result bit 7 and `flag_z` is 1 exactly when the result is 0x00. `flag_c`, `flag_n` and `flag_z` change only at instruction completion.
- R7: A word whose upper six bits differ from 001101 makes `illegal` pulse for one cycle, one clock after acceptance. No memory access occurs, no `done` is given, and `wreg` and the flags keep their values.
- R8: A legal instruction performs exactly one memory read and at most one write. `done` is high for one cycle, four rising edges after the accepting edge, with results already visible.
- R9: During and after reset, `wreg`, all flags, `done`, `illegal`, `mem_rd` and `mem_wr` are 0.
- R10: `instr_valid` is ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank-select value |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| mem_addr | output | 12 | Data memory address |
| mem_wdata | output | 8 | Data memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| wreg | output | 8 | Working register |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Unrecognised-opcode pulse |

## Verification
The assertions assume that `mem_rdata` returns the addressed byte exactly one cycle after `mem_rd`. They also assume that no other agent writes the operand location while an instruction is in flight. The bench memory model responds with that one-cycle latency. The bench preloads memory only while the block is idle, and it raises `instr_valid` during a busy period only in the test dedicated to R10.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_READ,
        ST_PROCESS,
        ST_WRITE
    } rlc_state_e;
endpackage

// File: rtl/rlc_decode.sv
module rlc_decode #(
    parameter int OPC_W  = 6,
    parameter int FILE_W = 8,
    parameter int BANK_W = 4,
    parameter logic [OPC_W-1:0] OPCODE = 6'b001101
) (
    input  logic [OPC_W+FILE_W+1:0] word,
    input  logic [BANK_W-1:0]       bank_sel,
    output logic                    match,
    output logic                    to_file,
    output logic [BANK_W+FILE_W-1:0] addr
);
    localparam int TOP = OPC_W + FILE_W + 1;
    localparam int D_POS = FILE_W + 1;
    localparam int A_POS = FILE_W;

    logic [FILE_W-1:0] offset;
    logic [BANK_W-1:0] fixed_bank;

    always_comb begin
        offset     = word[FILE_W-1:0];
        match      = (word[TOP -: OPC_W] == OPCODE);
        to_file    = word[D_POS];
        // upper half of the access window maps to the last bank
        fixed_bank = offset[FILE_W-1] ? {BANK_W{1'b1}} : {BANK_W{1'b0}};
        addr       = word[A_POS] ? {bank_sel, offset} : {fixed_bank, offset};
    end
endmodule

// File: rtl/rlc_rotate.sv
module rlc_rotate #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         neg,
    output logic         zero
);
    assign res[0] = cin;
    for (genvar b = 1; b < W; b++) begin : g_shift
        assign res[b] = opnd[b-1];
    end
    assign cout = opnd[W-1];
    assign neg  = res[W-1];
    assign zero = (res == '0);
endmodule

// File: rtl/rlc_exec.sv
module rlc_exec
    import rlc_pkg::*;
#(
    parameter int OPC_W  = 6,
    parameter int FILE_W = 8,
    parameter int BANK_W = 4,
    parameter int DATA_W = 8,
    parameter logic [OPC_W-1:0] OPCODE = 6'b001101
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_valid,
    input  logic [OPC_W+FILE_W+1:0]   instr,
    input  logic [BANK_W-1:0]         bsr,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [BANK_W+FILE_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [DATA_W-1:0]         wreg,
    output logic                      flag_c,
    output logic                      flag_n,
    output logic                      flag_z,
    output logic                      done,
    output logic                      illegal
);
    localparam int INSTR_W = OPC_W + FILE_W + 2;
    localparam int ADDR_W  = BANK_W + FILE_W;

    rlc_state_e state_q, state_d;

    logic [INSTR_W-1:0] instr_q;
    logic [BANK_W-1:0]  bsr_q;
    logic [DATA_W-1:0]  res_q, wreg_q;
    logic               cout_q, neg_q, zero_q;
    logic               c_q, n_q, z_q, done_q, illegal_q;

    logic               dec_match, dec_to_file;
    logic [ADDR_W-1:0]  dec_addr;
    logic [DATA_W-1:0]  rot_res;
    logic               rot_cout, rot_neg, rot_zero;

    rlc_decode #(
        .OPC_W(OPC_W), .FILE_W(FILE_W), .BANK_W(BANK_W), .OPCODE(OPCODE)
    ) u_decode (
        .word(instr_q), .bank_sel(bsr_q),
        .match(dec_match), .to_file(dec_to_file), .addr(dec_addr)
    );

    rlc_rotate #(.W(DATA_W)) u_rotate (
        .opnd(mem_rdata), .cin(c_q),
        .res(rot_res), .cout(rot_cout), .neg(rot_neg), .zero(rot_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (instr_valid) state_d = ST_DECODE;
            ST_DECODE:  state_d = dec_match ? ST_READ : ST_IDLE;
            ST_READ:    state_d = ST_PROCESS;
            ST_PROCESS: state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // registered datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q   <= '0;
            bsr_q     <= '0;
            res_q     <= '0;
            cout_q    <= 1'b0;
            neg_q     <= 1'b0;
            zero_q    <= 1'b0;
            wreg_q    <= '0;
            c_q       <= 1'b0;
            n_q       <= 1'b0;
            z_q       <= 1'b0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (instr_valid) begin
                        instr_q <= instr;
                        bsr_q   <= bsr;
                    end
                end
                ST_DECODE: illegal_q <= !dec_match;
                ST_READ: ;
                ST_PROCESS: begin
                    res_q  <= rot_res;
                    cout_q <= rot_cout;
                    neg_q  <= rot_neg;
                    zero_q <= rot_zero;
                end
                ST_WRITE: begin
                    if (!dec_to_file) wreg_q <= res_q;
                    c_q    <= cout_q;
                    n_q    <= neg_q;
                    z_q    <= zero_q;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_rd    = (state_q == ST_READ);
        mem_wr    = (state_q == ST_WRITE) && dec_to_file;
        mem_addr  = dec_addr;
        mem_wdata = res_q;
        wreg      = wreg_q;
        flag_c    = c_q;
        flag_n    = n_q;
        flag_z    = z_q;
        done      = done_q;
        illegal   = illegal_q;
    end

    // R8
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R3
    wr_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));
    // R6
    zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(flag_z && flag_n));
    // R7
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_rd && !mem_wr && !done && $stable(wreg) && $stable(flag_c)));
    // R4
    access_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !instr_q[FILE_W] && !instr_q[FILE_W-1]) |-> (mem_addr[ADDR_W-1:FILE_W] == '0));
    // R8
    done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_rd && !mem_wr && !illegal));
endmodule

// File: tb/rlc_exec_tb_top.sv
`timescale 1ns/1ps
module rlc_exec_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, instr_valid;
    logic [15:0] instr;
    logic [3:0]  bsr;
    logic        mem_rd, mem_wr, flag_c, flag_n, flag_z, done, illegal;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, wreg;

    rlc_exec dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .bsr(bsr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .wreg(wreg), .flag_c(flag_c), .flag_n(flag_n),
        .flag_z(flag_z), .done(done), .illegal(illegal)
    );

    logic [7:0]  mem [4096];
    logic        pre_en = 1'b0;
    logic [11:0] pre_addr = '0;
    logic [7:0]  pre_data = '0;
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (pre_en) mem[pre_addr] <= pre_data;
    end

    int tests = 0, fails = 0;
    logic       mc = 1'b0;
    logic [7:0] mw = 8'h00;
    int n_done_at, n_done, n_rd, n_wr, n_ill;

    // {instr, bsr, operand}
    localparam logic [27:0] VEC [8] = '{
        {16'h3405, 4'h3, 8'hE6}, {16'h3690, 4'h7, 8'h81},
        {16'h3510, 4'h2, 8'h00}, {16'h3722, 4'hA, 8'h80},
        {16'h347F, 4'h5, 8'hFF}, {16'h3480, 4'h5, 8'h40},
        {16'h35FF, 4'hF, 8'h7F}, {16'h3700, 4'h0, 8'h01}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk); pre_en = 1'b0;
    endtask

    function automatic logic [11:0] exp_addr(input logic [15:0] w, input logic [3:0] b);
        if (w[8]) return {b, w[7:0]};
        return {w[7] ? 4'hF : 4'h0, w[7:0]};
    endfunction

    task automatic run(input logic [15:0] w, input logic [3:0] b,
                       input logic hold, input logic [15:0] w2);
        @(negedge clk); instr = w; bsr = b; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = hold; instr = w2; bsr = ~b;
        n_done_at = 0; n_done = 0; n_rd = 0; n_wr = 0; n_ill = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k >= 3) instr_valid = 1'b0;
            if (mem_rd) n_rd++;
            if (mem_wr) n_wr++;
            if (illegal) n_ill++;
            if (done) begin n_done++; if (n_done_at == 0) n_done_at = k; end
        end
        instr_valid = 1'b0;
    endtask

    task automatic legal(input logic [15:0] w, input logic [3:0] b, input logic [7:0] op,
                         input logic hold, input logic [15:0] w2);
        logic [11:0] a;
        logic [7:0]  r;
        logic        cn;
        a  = exp_addr(w, b);
        r  = {op[6:0], mc};
        cn = op[7];
        preload(a, op);
        run(w, b, hold, w2);
        chk(n_done_at == 4 && n_done == 1, "R8 done timing", n_done_at, 4);
        chk(n_rd == 1 && n_wr == int'(w[9]), "R8 access count", n_rd*16 + n_wr, 16 + int'(w[9]));
        if (w[9]) begin
            chk(mem[a] == r, "R3 file write", mem[a], r);
            chk(wreg == mw, "R3 wreg kept", wreg, mw);
        end else begin
            chk(wreg == r, "R1 wreg result", wreg, r);
            chk(mem[a] == op, "R3 file kept", mem[a], op);
            mw = r;
        end
        chk(flag_c == cn, "R1 carry", flag_c, cn);
        chk(flag_n == r[7] && flag_z == (r == 8'h00), "R6 flags",
            {flag_n, flag_z}, {r[7], r == 8'h00});
        mc = cn;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0; bsr = '0;
        repeat (3) @(negedge clk);
        // R9
        chk(wreg == 0 && !flag_c && !flag_n && !flag_z, "R9 reset regs", wreg, 0);
        chk(!done && !illegal && !mem_rd && !mem_wr, "R9 reset strobes",
            {done, illegal, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        // R1 worked example: operand 0xE6, carry 0, to wreg
        legal(16'h3420, 4'h9, 8'hE6, 1'b0, 16'h0);
        chk(wreg == 8'hCC && flag_c, "R1 example", {flag_c, wreg}, 9'h1CC);

        // R2 R5 table walk
        for (int i = 0; i < 8; i++)
            legal(VEC[i][27:12], VEC[i][11:8], VEC[i][7:0], 1'b0, 16'h0);

        // R4 bsr ignored in access mode
        preload(12'hF10, 8'hAA);
        legal(16'h3410, 4'hF, 8'h55, 1'b0, 16'h0);
        chk(mem[12'hF10] == 8'hAA, "R4 banked copy untouched", mem[12'hF10], 8'hAA);

        // R7 illegal opcodes, including neighbours of the match pattern
        begin
            logic [7:0] w0;
            logic [2:0] f0;
            w0 = wreg; f0 = {flag_c, flag_n, flag_z};
            preload(12'h005, 8'h3C);
            run(16'h3C05, 4'h0, 1'b0, 16'h0);
            chk(n_ill == 1 && n_rd == 0 && n_wr == 0 && n_done == 0, "R7 quiet",
                {n_ill, n_rd, n_wr, n_done}, 1);
            run(16'h3005, 4'h0, 1'b0, 16'h0);
            chk(n_ill == 1 && n_rd == 0 && n_done == 0, "R2 near opcode", n_ill, 1);
            chk(wreg == w0 && {flag_c, flag_n, flag_z} == f0, "R7 state kept", wreg, w0);
            chk(mem[12'h005] == 8'h3C, "R7 memory kept", mem[12'h005], 8'h3C);
        end

        // R10 second valid word while busy is dropped
        begin
            logic [7:0] wk;
            wk = mw;
            legal(16'h3640, 4'h1, 8'h11, 1'b1, 16'h3441);
            chk(wreg == wk, "R10 busy word ignored", wreg, wk);
            repeat (3) @(negedge clk);
            chk(!mem_rd && !done && !illegal, "R10 no late start", {mem_rd, done}, 0);
        end

        // R9 reset mid-flight clears state
        @(negedge clk); instr = 16'h3420; instr_valid = 1'b1;
        @(negedge clk); instr_valid = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(wreg == 0 && !flag_c && !mem_rd && !mem_wr && !done, "R9 mid reset", wreg, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!done && !mem_wr, "R9 no resume", {done, mem_wr}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule